// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block watches a parallel flash device while it runs an embedded program or erase. It starts after the command has already been written. It then decides whether the operation ended cleanly, failed inside the device, or ran past its time budget. The block first tracks the device's ready/busy line: it waits for the line to drop, then waits for it to come back. It then starts polling. Each pass fetches the status word twice in a row and compares the toggle bit between the two words. While the bit keeps flipping, the device is still busy. When it holds still, the operation is complete.

The device can also raise a fault flag while the toggle bit is still flipping. When that happens, the block does not declare an error right away. It takes one more pair of reads, and a toggle bit that has settled in that pair still counts as success. Every wait and the polling loop are bounded by a count loaded at start. The count depends on the kind of operation. The outcome appears on a two-bit result code, together with a one-cycle completion strobe.

Status words are fetched through a simple request/valid handshake. The block raises `rd_req` and keeps it high. Each cycle in which `rd_valid` is high delivers one word on `rd_data`.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: The ready/busy input passes through a two-flop synchronizer. No status read is requested before the synchronized line is seen high, so the first request comes no sooner than the fourth cycle after the line rises.
- R2: After start, the block waits for ready/busy to go low, then for it to go high. Each wait ends after the loaded count of cycles even if the line never changes, and polling then begins.
- R3: A poll pass reads two status words. If bit 6 is equal in both words, the run ends with result 01 (success).
- R4: If bit 6 differs within a pass and bit 5 of the first word of that pass is clear, the block starts another pass. Bit 5 of the second word is not examined.
- R5: If bit 6 differs and bit 5 of the first word is set, a confirming pair is read. If bit 6 differs across that pair too, the result is 10 (error).
- R6: If bit 6 is equal across the confirming pair, the result is 01 (success).
- R7: Each pass consumes one count. When the count is zero at the start of a pass, the result is 11 (timeout), so a run that never settles issues exactly two reads per counted pass.
- R8: The count is chosen by `op_sel`: 00 word program (T_PROG), 01 sector erase (T_SECT), 10 or 11 chip erase (T_CHIP).
- R9: `done` is high for exactly one cycle per run. `result` reads 00 after reset and changes only in the cycle where `done` is high.
- R10: A start pulse that arrives while a run is in progress is ignored. The run keeps its count and its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| op_sel | input | 2 | Operation kind, selects the count budget |
| rb_in | input | 1 | Asynchronous ready/busy line, low while busy |
| rd_req | output | 1 | Status read request, held until a word arrives |
| rd_valid | input | 1 | Status word valid on rd_data |
| rd_data | input | DW | Status word from the device |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | 00 none, 01 success, 10 error, 11 timeout |

## Verification
Several properties are checked on every cycle. The strobe is a single-cycle pulse, and the result moves only with the strobe. Read requests occur only in the polling states. An error outcome always follows a confirming pair, and a timeout outcome always means the pass budget is used up. A start pulse during a run leaves the chosen budget untouched. Other properties can only be shown by the bench's scenarios, which play scripted status-word sequences against a read model. These are the exact verdict for each bit-6/bit-5 pattern, the number of reads per budget for each operation kind, the synchronizer's latency measured against the ready edge, and a ready line stuck low.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic [1:0] {
        RES_NONE = 2'b00,
        RES_OK   = 2'b01,
        RES_FAIL = 2'b10,
        RES_TMO  = 2'b11
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBUSY,
        ST_WREADY,
        ST_CHECK,
        ST_PAIR1,
        ST_PAIR2
    } ctl_st_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_A,
        RD_B
    } rd_st_e;

endpackage

// File: rtl/tbp_sync.sv
module tbp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= RST_VAL;
                else        sh_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RST_VAL}};
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tbp_pair_reader.sv
module tbp_pair_reader
    import tbp_pkg::*;
#(
    parameter int DW       = 16,
    parameter int TOG_BIT  = 6,
    parameter int FAIL_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          rd_req,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          pair_done,
    output logic          toggled,
    output logic          fail_seen
);
    typedef struct packed {
        rd_st_e st;
        logic   a_tog;
        logic   a_fail;
        logic   done;
        logic   tog;
        logic   fail;
    } rd_regs_t;

    rd_regs_t q_q, q_d;

    // only two bits of each word matter to the verdict
    logic unused_word_bits;
    assign unused_word_bits = ^rd_data;

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        case (q_q.st)
            RD_IDLE: if (go) q_d.st = RD_A;
            RD_A: if (rd_valid) begin
                q_d.a_tog  = rd_data[TOG_BIT];
                q_d.a_fail = rd_data[FAIL_BIT];
                q_d.st     = RD_B;
            end
            RD_B: if (rd_valid) begin
                q_d.tog  = q_q.a_tog ^ rd_data[TOG_BIT];
                q_d.fail = q_q.a_fail;
                q_d.done = 1'b1;
                q_d.st   = RD_IDLE;
            end
            default: q_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: RD_IDLE, default: 1'b0};
        else        q_q <= q_d;
    end

    assign rd_req    = (q_q.st != RD_IDLE);
    assign pair_done = q_q.done;
    assign toggled   = q_q.tog;
    assign fail_seen = q_q.fail;

    // R3: a verdict comes only after the second word, and the request drops with it
    assert_pair_after_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |-> !rd_req && $past(rd_req));

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
    import tbp_pkg::*;
#(
    parameter int          DW          = 16,
    parameter int          TOG_BIT     = 6,
    parameter int          FAIL_BIT    = 5,
    parameter int          CW          = 32,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned T_PROG      = 5120,
    parameter int unsigned T_SECT      = 10485760,
    parameter int unsigned T_CHIP      = 805306368
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_sel,
    input  logic          rb_in,
    output logic          rd_req,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        ctl_st_e       st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] load;
        logic          go;
        logic          done;
        res_e          res;
    } ctl_regs_t;

    ctl_regs_t q_q, q_d;

    logic rb_s;
    logic pair_done, toggled, fail_seen;

    function automatic logic [CW-1:0] tmo_for(input logic [1:0] op);
        case (op)
            2'b00:   return CW'(T_PROG);
            2'b01:   return CW'(T_SECT);
            default: return CW'(T_CHIP);
        endcase
    endfunction

    tbp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rb_in),
        .q     (rb_s)
    );

    tbp_pair_reader #(.DW(DW), .TOG_BIT(TOG_BIT), .FAIL_BIT(FAIL_BIT)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (q_q.go),
        .rd_req    (rd_req),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .pair_done (pair_done),
        .toggled   (toggled),
        .fail_seen (fail_seen)
    );

    always_comb begin
        q_d      = q_q;
        q_d.go   = 1'b0;
        q_d.done = 1'b0;
        case (q_q.st)
            ST_IDLE: if (start) begin
                q_d.load = tmo_for(op_sel);
                q_d.cnt  = tmo_for(op_sel);
                q_d.st   = ST_WBUSY;
            end
            ST_WBUSY: begin
                if (!rb_s || q_q.cnt == '0) begin
                    q_d.cnt = q_q.load;
                    q_d.st  = ST_WREADY;
                end else begin
                    q_d.cnt = q_q.cnt - ONE;
                end
            end
            ST_WREADY: begin
                if (rb_s || q_q.cnt == '0) begin
                    q_d.cnt = q_q.load;
                    q_d.st  = ST_CHECK;
                end else begin
                    q_d.cnt = q_q.cnt - ONE;
                end
            end
            ST_CHECK: begin
                if (q_q.cnt == '0) begin
                    q_d.res  = RES_TMO;
                    q_d.done = 1'b1;
                    q_d.st   = ST_IDLE;
                end else begin
                    q_d.cnt = q_q.cnt - ONE;
                    q_d.go  = 1'b1;
                    q_d.st  = ST_PAIR1;
                end
            end
            ST_PAIR1: if (pair_done) begin
                if (!toggled) begin
                    q_d.res  = RES_OK;
                    q_d.done = 1'b1;
                    q_d.st   = ST_IDLE;
                end else if (!fail_seen) begin
                    q_d.st = ST_CHECK;
                end else begin
                    q_d.go = 1'b1;
                    q_d.st = ST_PAIR2;
                end
            end
            ST_PAIR2: if (pair_done) begin
                q_d.res  = toggled ? RES_FAIL : RES_OK;
                q_d.done = 1'b1;
                q_d.st   = ST_IDLE;
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: ST_IDLE, cnt: '0, load: '0, go: 1'b0, done: 1'b0, res: RES_NONE};
        else        q_q <= q_d;
    end

    assign busy   = (q_q.st != ST_IDLE);
    assign done   = q_q.done;
    assign result = q_q.res;

    // R9: completion strobe never lasts two cycles
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: result holds between completions
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R1: status reads happen only once polling has begun
    assert_req_only_polling_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (q_q.st == ST_PAIR1 || q_q.st == ST_PAIR2));

    // R2: a synchronized ready line ends the ready wait on the next edge
    assert_ready_wait_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_WREADY && rb_s) |=> q_q.st == ST_CHECK);

    // R5: an error verdict always follows a confirming pair
    assert_error_after_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_FAIL) |-> $past(q_q.st) == ST_PAIR2);

    // R7: a timeout verdict means the pass budget is exhausted
    assert_timeout_exhaust_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_TMO) |-> q_q.cnt == '0);

    // R10: a start pulse during a run leaves the budget untouched
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q_q.load));

endmodule

// File: tb/sim_toggle_poll_ctrl.sv
`timescale 1ns/1ps
module sim_toggle_poll_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        rb_in;
    logic        rd_req;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = 16'h0000;
    logic        busy, done;
    logic [1:0]  result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    int rb_len_r = 0;
    int cur_v = 0;
    int rd_idx = 0;
    int rd_base = 0;
    int first_req_cyc = 0;

    always #2.5 clk = ~clk;

    toggle_poll_ctrl #(.T_PROG(3), .T_SECT(5), .T_CHIP(12)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .rb_in(rb_in),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .result(result)
    );

    // vector table: op, ready-low length, expected result, expected reads, 8 words each
    localparam logic [1:0] VOP  [0:7] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd0};
    localparam int         VRB  [0:7] = '{4, 6, 3, 0, 5, 2, 8, 4};
    localparam logic [1:0] VRES [0:7] = '{2'b01, 2'b01, 2'b10, 2'b01, 2'b11, 2'b11, 2'b10, 2'b01};
    localparam int         VRD  [0:7] = '{2, 4, 4, 4, 6, 10, 4, 6};
    localparam logic [15:0] VW [0:63] = '{
        16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0040, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0060, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0060, 16'h0000, 16'h0040, 16'h0040, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040,
        16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040,
        16'h0020, 16'h0060, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0040, 16'h0020, 16'h0000, 16'h0040, 16'h0040, 16'h0040, 16'h0000, 16'h0000
    };

    function automatic string req_of(input int v);
        case (v)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R5";
            default: return "R4";
        endcase
    endfunction

    assign rb_in = (rb_len_r != 0 && (cyc - start_cyc) < rb_len_r) ? 1'b0 : 1'b1;

    always @(negedge clk) cyc <= cyc + 1;

    // status-word source: one word per request, every other cycle
    always @(negedge clk) begin
        if (rd_req && !rd_valid) begin
            int k;
            k = rd_idx - rd_base;
            if (k == 0) first_req_cyc = cyc;
            rd_data  <= (k < 8) ? VW[cur_v*8 + k] : (k[0] ? 16'h0040 : 16'h0000);
            rd_valid <= 1'b1;
            rd_idx   <= rd_idx + 1;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int v, input logic [1:0] op, input int rbl, input bit mid_start,
                       input logic [1:0] exp_res, input int exp_reads, input string req,
                       output int n_cyc);
        int n;
        step();
        op_sel = op; start = 1'b1; cur_v = v; rd_base = rd_idx; start_cyc = cyc; rb_len_r = rbl;
        step();
        start = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            step();
            n++;
            start  = (mid_start && n == 10);
            if (mid_start && n == 10) op_sel = 2'b10;
        end
        start = 1'b0;
        n_cyc = n;
        chk(result == exp_res, req, result, exp_res);
        chk((rd_idx - rd_base) == exp_reads, req, rd_idx - rd_base, exp_reads);
        step();
        chk(!done && !busy, "R9", done, 0);
        step(); step();
        chk(result == exp_res, "R9", result, exp_res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nc;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R9: reset state
        chk(result == 2'b00, "R9", result, 0);
        chk(!done && !busy && !rd_req, "R9", {done, busy, rd_req}, 0);

        for (int v = 0; v < 8; v++) begin
            run(v, VOP[v], VRB[v], 1'b0, VRES[v], VRD[v], req_of(v), nc);
        end

        // R8: same never-settling pattern, chip budget gives 24 reads
        run(4, 2'b10, 3, 1'b0, 2'b11, 24, "R8", nc);

        // R1: first read no sooner than four cycles after ready rises
        run(0, 2'b10, 6, 1'b0, 2'b01, 2, "R1", nc);
        chk(first_req_cyc - (start_cyc + 6) >= 4, "R1", first_req_cyc - (start_cyc + 6), 4);

        // R2: ready line stuck low, waits are bounded and polling proceeds
        run(0, 2'b00, 200, 1'b0, 2'b01, 2, "R2", nc);
        chk(nc < 40, "R2", nc, 40);

        // R10: start during a program run does not switch to the chip budget
        run(4, 2'b00, 2, 1'b1, 2'b11, 6, "R10", nc);

        rb_len_r = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule